// File: doc/BRIEF.md
# IDE DMA Chunk Sequencer

This block drives one IDE DMA transfer as a series of chunks handed to it by a descriptor-driven memory DMA channel. A start pulse carries the command, sector count, block address, drive kind and optical packet size. The sequencer then holds a signed count of bytes still to move and a running byte index. Each chunk that the channel offers (a memory address and a byte length) is turned into one request to the storage backend. The request carries a device byte offset built from the block address and the bytes already moved.

Disk drives address in 512-byte sectors and optical drives in 2048-byte blocks, so the two kinds use different shifts. Three endings are kept apart. The end of a chunk returns control to the channel. The end of the transfer also sets a drive status and raises the interrupt. An abort sets an error status, the error flag and the interrupt. A chunk offered while no transfer is active is handed back unprocessed, so that the channel can present it again after a restart.

Top module: `ide_chunk_seq`

## Requirements
- R1: After reset, status_o is 0x00, irq_o, err_o and active_o are low, and chunk_rdy_o is high.
- R2: A start pulse accepted while chunk_rdy_o is high does the following: it clears the running index, loads the remaining count (sector count times 512 for a disk, the packet size for an optical drive), sets active_o, sets status_o to 0x80, and clears irq_o and err_o.
- R3: The device offset of a chunk is (block address << 9) + index for a disk (optical_i=0) and (block address << 11) + index for an optical drive (optical_i=1).
- R4: Each issued chunk lowers the remaining count by the chunk length and raises the index by it, so the next chunk's offset advances by that length.
- R5: The command code selects the backend operation. cmd_i values 0 (read), 1 (write) and 2 (trim) map to be_op_o 0, 1 and 2, with be_addr_o and be_len_o equal to the chunk address and length. be_op_o 3 marks a buffer copy.
- R6: Only one backend request is outstanding at a time. be_req_o and its fields stay unchanged until be_done_i, and chunk_rdy_o stays low while a request is pending.
- R7: A chunk offered while active_o is low produces a one-cycle chunk_park_o pulse and no backend request.
- R8: If the remaining count is zero or negative when a chunk is evaluated, or after a backend request completes, the transfer ends. status_o becomes 0x50, irq_o rises, active_o falls, and chunk_end_o pulses.
- R9: A zero-length chunk pulses chunk_end_o and issues no request. irq_o stays low and active_o stays high.
- R10: For an optical drive whose block address is all ones, the chunk becomes a single copy request (be_op_o 3, offset 0) with length equal to the smaller of the remaining count and the chunk length. The transfer completes when that request is done.
- R11: A backend completion with be_err_i high aborts the transfer. status_o becomes 0x41, and err_o and irq_o rise while active_o falls.
- R12: With the unknown command code 3, a chunk issues no request and aborts the transfer as in R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse for a transfer |
| cmd_i | input | 2 | Command: 0 read, 1 write, 2 trim, 3 unknown |
| nsect_i | input | SECT_W | Sector count (disk) |
| lba_i | input | LBA_W | Start sector or block address |
| optical_i | input | 1 | 1 selects an optical drive |
| pkt_size_i | input | CNT_W | Optical transfer size in bytes |
| chunk_vld_i | input | 1 | Channel offers a chunk |
| chunk_addr_i | input | ADDR_W | Memory address of the chunk |
| chunk_len_i | input | LEN_W | Byte length of the chunk |
| chunk_rdy_o | output | 1 | Sequencer can take a chunk or start |
| chunk_end_o | output | 1 | Pulse: current chunk finished |
| chunk_park_o | output | 1 | Pulse: chunk returned, no active transfer |
| be_req_o | output | 1 | Backend request pending |
| be_op_o | output | 2 | 0 read, 1 write, 2 trim, 3 copy |
| be_addr_o | output | ADDR_W | Memory address for the request |
| be_off_o | output | LBA_W+12 | Device byte offset |
| be_len_o | output | LEN_W | Request length in bytes |
| be_done_i | input | 1 | Backend completion pulse |
| be_err_i | input | 1 | Error qualifier for be_done_i |
| status_o | output | 8 | Drive status value |
| irq_o | output | 1 | Completion or error interrupt |
| err_o | output | 1 | Transfer aborted |
| active_o | output | 1 | Transfer in progress |

## Verification
The hardest case to reach is a remaining count that has gone negative. This happens when a chunk is longer than the bytes left, and the transfer must then end on the following completion rather than on a zero count. A one-sector trim fed a 1024-byte chunk drives the count to -512. The zero-sector start separately covers the case where the transfer ends at chunk evaluation with no request. The parked case needs a chunk with no active transfer, so it is offered right after a completed transfer. The block-address-less copy needs the all-ones address on an optical start, and it is run with the packet size both below and above the chunk length so that both sides of the minimum are seen.

// File: rtl/ics_pkg.sv
package ics_pkg;

    typedef enum logic [1:0] {
        CMD_READ  = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_TRIM  = 2'd2,
        CMD_BAD   = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_TRIM  = 2'd2,
        OP_COPY  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_EVAL  = 2'd1,
        ST_WAIT  = 2'd2
    } state_e;

    localparam logic [7:0] STAT_IDLE = 8'h00;
    localparam logic [7:0] STAT_BUSY = 8'h80;
    localparam logic [7:0] STAT_DONE = 8'h50;
    localparam logic [7:0] STAT_FAIL = 8'h41;

    function automatic op_e cmd_to_op(cmd_e c);
        case (c)
            CMD_READ:  return OP_READ;
            CMD_WRITE: return OP_WRITE;
            default:   return OP_TRIM;
        endcase
    endfunction

endpackage

// File: rtl/ics_offset.sv
module ics_offset #(
    parameter int LBA_W        = 28,
    parameter int IDX_W        = 25,
    parameter int OFF_W        = 40,
    parameter int SECTOR_SHIFT = 9,
    parameter int BLOCK_SHIFT  = 11
) (
    input  logic [LBA_W-1:0] lba_i,
    input  logic             optical_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [OFF_W-1:0] off_o,
    output logic             no_lba_o
);
    logic [OFF_W-1:0] base;

    always_comb begin
        if (optical_i)
            base = OFF_W'(lba_i) << BLOCK_SHIFT;
        else
            base = OFF_W'(lba_i) << SECTOR_SHIFT;
        off_o    = base + OFF_W'(idx_i);
        no_lba_o = &lba_i;
    end
endmodule

// File: rtl/ics_tally.sv
module ics_tally #(
    parameter int SECT_W       = 8,
    parameter int CNT_W        = 24,
    parameter int LEN_W        = 16,
    parameter int SECTOR_SHIFT = 9,
    localparam int REM_W       = CNT_W + 1,
    localparam int IDX_W       = CNT_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load_i,
    input  logic                    optical_i,
    input  logic [SECT_W-1:0]       nsect_i,
    input  logic [CNT_W-1:0]        pkt_i,
    input  logic                    consume_i,
    input  logic [LEN_W-1:0]        len_i,
    output logic signed [REM_W-1:0] rem_o,
    output logic [IDX_W-1:0]        idx_o,
    output logic                    drained_o
);
    logic signed [REM_W-1:0] rem_q;
    logic [IDX_W-1:0]        idx_q;
    logic signed [REM_W-1:0] len_s;

    assign len_s = {{(REM_W-LEN_W){1'b0}}, len_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            idx_q <= '0;
        end else if (load_i) begin
            idx_q <= '0;
            if (optical_i)
                rem_q <= {1'b0, pkt_i};
            else
                rem_q <= REM_W'(nsect_i) << SECTOR_SHIFT;
        end else if (consume_i) begin
            rem_q <= rem_q - len_s;
            idx_q <= idx_q + IDX_W'(len_i);
        end
    end

    assign rem_o     = rem_q;
    assign idx_o     = idx_q;
    assign drained_o = rem_q[REM_W-1] || (rem_q == '0);
endmodule

// File: rtl/ics_ctrl.sv
module ics_ctrl
    import ics_pkg::*;
#(
    parameter int LBA_W  = 28,
    parameter int LEN_W  = 16,
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [1:0]        cmd_i,
    input  logic              optical_i,
    input  logic [LBA_W-1:0]  lba_i,
    input  logic              chunk_vld_i,
    input  logic [ADDR_W-1:0] chunk_addr_i,
    input  logic [LEN_W-1:0]  chunk_len_i,
    input  logic              be_done_i,
    input  logic              be_err_i,
    input  logic              drained_i,
    input  logic              no_lba_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [LEN_W-1:0]  copy_len_i,
    output logic              opt_o,
    output logic [LBA_W-1:0]  lba_o,
    output logic              load_o,
    output logic              consume_o,
    output logic [LEN_W-1:0]  len_o,
    output logic              chunk_rdy_o,
    output logic              chunk_end_o,
    output logic              chunk_park_o,
    output logic              be_req_o,
    output logic [1:0]        be_op_o,
    output logic [ADDR_W-1:0] be_addr_o,
    output logic [OFF_W-1:0]  be_off_o,
    output logic [LEN_W-1:0]  be_len_o,
    output logic [7:0]        status_o,
    output logic              irq_o,
    output logic              err_o,
    output logic              active_o
);
    state_e            state_q;
    cmd_e              cmd_q;
    logic              opt_q;
    logic [LBA_W-1:0]  lba_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic              copy_q;
    logic              active_q, irq_q, err_q;
    logic [7:0]        status_q;
    logic              end_q, park_q;
    logic              req_q;
    op_e               op_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic [OFF_W-1:0]  req_off_q;
    logic [LEN_W-1:0]  req_len_q;

    logic take_start, take_chunk, issue_blk;

    always_comb begin
        take_start = (state_q == ST_READY) && start_i;
        take_chunk = (state_q == ST_READY) && !start_i && chunk_vld_i;
        issue_blk  = (state_q == ST_EVAL) && active_q && !drained_i &&
                     (len_q != '0) && !(opt_q && no_lba_i) && (cmd_q != CMD_BAD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_READY;
            cmd_q      <= CMD_READ;
            opt_q      <= 1'b0;
            lba_q      <= '0;
            addr_q     <= '0;
            len_q      <= '0;
            copy_q     <= 1'b0;
            active_q   <= 1'b0;
            irq_q      <= 1'b0;
            err_q      <= 1'b0;
            status_q   <= STAT_IDLE;
            end_q      <= 1'b0;
            park_q     <= 1'b0;
            req_q      <= 1'b0;
            op_q       <= OP_READ;
            req_addr_q <= '0;
            req_off_q  <= '0;
            req_len_q  <= '0;
        end else begin
            end_q  <= 1'b0;
            park_q <= 1'b0;
            case (state_q)
                ST_READY: begin
                    if (take_start) begin
                        cmd_q    <= cmd_e'(cmd_i);
                        opt_q    <= optical_i;
                        lba_q    <= lba_i;
                        active_q <= 1'b1;
                        irq_q    <= 1'b0;
                        err_q    <= 1'b0;
                        status_q <= STAT_BUSY;
                    end else if (take_chunk) begin
                        addr_q  <= chunk_addr_i;
                        len_q   <= chunk_len_i;
                        state_q <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    state_q <= ST_READY;
                    if (!active_q) begin
                        park_q <= 1'b1;
                    end else if (drained_i) begin
                        end_q    <= 1'b1;
                        status_q <= STAT_DONE;
                        irq_q    <= 1'b1;
                        active_q <= 1'b0;
                    end else if (len_q == '0) begin
                        end_q <= 1'b1;
                    end else if (opt_q && no_lba_i) begin
                        req_q      <= 1'b1;
                        op_q       <= OP_COPY;
                        req_addr_q <= addr_q;
                        req_off_q  <= '0;
                        req_len_q  <= copy_len_i;
                        copy_q     <= 1'b1;
                        state_q    <= ST_WAIT;
                    end else if (cmd_q == CMD_BAD) begin
                        end_q    <= 1'b1;
                        status_q <= STAT_FAIL;
                        irq_q    <= 1'b1;
                        err_q    <= 1'b1;
                        active_q <= 1'b0;
                    end else begin
                        req_q      <= 1'b1;
                        op_q       <= cmd_to_op(cmd_q);
                        req_addr_q <= addr_q;
                        req_off_q  <= off_i;
                        req_len_q  <= len_q;
                        copy_q     <= 1'b0;
                        state_q    <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (be_done_i) begin
                        req_q   <= 1'b0;
                        end_q   <= 1'b1;
                        state_q <= ST_READY;
                        if (be_err_i) begin
                            status_q <= STAT_FAIL;
                            irq_q    <= 1'b1;
                            err_q    <= 1'b1;
                            active_q <= 1'b0;
                        end else if (copy_q || drained_i) begin
                            status_q <= STAT_DONE;
                            irq_q    <= 1'b1;
                            active_q <= 1'b0;
                        end
                    end
                end
                default: state_q <= ST_READY;
            endcase
        end
    end

    assign opt_o        = opt_q;
    assign lba_o        = lba_q;
    assign load_o       = take_start;
    assign consume_o    = issue_blk;
    assign len_o        = len_q;
    assign chunk_rdy_o  = (state_q == ST_READY);
    assign chunk_end_o  = end_q;
    assign chunk_park_o = park_q;
    assign be_req_o     = req_q;
    assign be_op_o      = op_q;
    assign be_addr_o    = req_addr_q;
    assign be_off_o     = req_off_q;
    assign be_len_o     = req_len_q;
    assign status_o     = status_q;
    assign irq_o        = irq_q;
    assign err_o        = err_q;
    assign active_o     = active_q;

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (be_req_o && !be_done_i) |=> (be_req_o && $stable(be_off_o) && $stable(be_len_o)));

    // R6
    single_out_chk: assert property (@(posedge clk) disable iff (rst)
        be_req_o |-> !chunk_rdy_o);

    // R7
    park_idle_chk: assert property (@(posedge clk) disable iff (rst)
        chunk_park_o |-> (!active_o && !be_req_o));

    // R8
    irq_ends_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> (!active_o && chunk_end_o));

    // R9
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(chunk_end_o && chunk_park_o));
endmodule

// File: rtl/ide_chunk_seq.sv
module ide_chunk_seq #(
    parameter int LBA_W        = 28,
    parameter int SECT_W       = 8,
    parameter int CNT_W        = 24,
    parameter int LEN_W        = 16,
    parameter int ADDR_W       = 32,
    parameter int SECTOR_SHIFT = 9,
    parameter int BLOCK_SHIFT  = 11,
    localparam int REM_W       = CNT_W + 1,
    localparam int IDX_W       = CNT_W + 1,
    localparam int OFF_W       = LBA_W + BLOCK_SHIFT + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [1:0]        cmd_i,
    input  logic [SECT_W-1:0] nsect_i,
    input  logic [LBA_W-1:0]  lba_i,
    input  logic              optical_i,
    input  logic [CNT_W-1:0]  pkt_size_i,
    input  logic              chunk_vld_i,
    input  logic [ADDR_W-1:0] chunk_addr_i,
    input  logic [LEN_W-1:0]  chunk_len_i,
    output logic              chunk_rdy_o,
    output logic              chunk_end_o,
    output logic              chunk_park_o,
    output logic              be_req_o,
    output logic [1:0]        be_op_o,
    output logic [ADDR_W-1:0] be_addr_o,
    output logic [OFF_W-1:0]  be_off_o,
    output logic [LEN_W-1:0]  be_len_o,
    input  logic              be_done_i,
    input  logic              be_err_i,
    output logic [7:0]        status_o,
    output logic              irq_o,
    output logic              err_o,
    output logic              active_o
);
    logic                    opt_w, load_w, consume_w, drained_w, no_lba_w;
    logic [LBA_W-1:0]        lba_w;
    logic [LEN_W-1:0]        len_w, copy_len_w;
    logic signed [REM_W-1:0] rem_w;
    logic [IDX_W-1:0]        idx_w;
    logic [OFF_W-1:0]        off_w;
    logic [CNT_W-1:0]        rem_mag;

    assign rem_mag    = rem_w[CNT_W-1:0];
    assign copy_len_w = (CNT_W'(len_w) < rem_mag) ? len_w : rem_mag[LEN_W-1:0];

    ics_tally #(
        .SECT_W(SECT_W), .CNT_W(CNT_W), .LEN_W(LEN_W), .SECTOR_SHIFT(SECTOR_SHIFT)
    ) u_tally (
        .clk(clk), .rst(rst), .load_i(load_w), .optical_i(optical_i),
        .nsect_i(nsect_i), .pkt_i(pkt_size_i), .consume_i(consume_w),
        .len_i(len_w), .rem_o(rem_w), .idx_o(idx_w), .drained_o(drained_w)
    );

    ics_offset #(
        .LBA_W(LBA_W), .IDX_W(IDX_W), .OFF_W(OFF_W),
        .SECTOR_SHIFT(SECTOR_SHIFT), .BLOCK_SHIFT(BLOCK_SHIFT)
    ) u_offset (
        .lba_i(lba_w), .optical_i(opt_w), .idx_i(idx_w),
        .off_o(off_w), .no_lba_o(no_lba_w)
    );

    ics_ctrl #(
        .LBA_W(LBA_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)
    ) u_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i), .cmd_i(cmd_i),
        .optical_i(optical_i), .lba_i(lba_i),
        .chunk_vld_i(chunk_vld_i), .chunk_addr_i(chunk_addr_i), .chunk_len_i(chunk_len_i),
        .be_done_i(be_done_i), .be_err_i(be_err_i),
        .drained_i(drained_w), .no_lba_i(no_lba_w), .off_i(off_w), .copy_len_i(copy_len_w),
        .opt_o(opt_w), .lba_o(lba_w), .load_o(load_w), .consume_o(consume_w), .len_o(len_w),
        .chunk_rdy_o(chunk_rdy_o), .chunk_end_o(chunk_end_o), .chunk_park_o(chunk_park_o),
        .be_req_o(be_req_o), .be_op_o(be_op_o), .be_addr_o(be_addr_o),
        .be_off_o(be_off_o), .be_len_o(be_len_o),
        .status_o(status_o), .irq_o(irq_o), .err_o(err_o), .active_o(active_o)
    );
endmodule

// File: tb/ide_chunk_seq_tb.sv
module ide_chunk_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [1:0]  cmd_i = 2'd0;
    logic [7:0]  nsect_i = '0;
    logic [27:0] lba_i = '0;
    logic        optical_i = 1'b0;
    logic [23:0] pkt_size_i = '0;
    logic        chunk_vld_i = 1'b0;
    logic [31:0] chunk_addr_i = '0;
    logic [15:0] chunk_len_i = '0;
    logic        be_done_i = 1'b0;
    logic        be_err_i = 1'b0;
    logic        chunk_rdy_o, chunk_end_o, chunk_park_o, be_req_o;
    logic [1:0]  be_op_o;
    logic [31:0] be_addr_o;
    logic [39:0] be_off_o;
    logic [15:0] be_len_o;
    logic [7:0]  status_o;
    logic        irq_o, err_o, active_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ide_chunk_seq u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .cmd_i(cmd_i), .nsect_i(nsect_i),
        .lba_i(lba_i), .optical_i(optical_i), .pkt_size_i(pkt_size_i),
        .chunk_vld_i(chunk_vld_i), .chunk_addr_i(chunk_addr_i), .chunk_len_i(chunk_len_i),
        .chunk_rdy_o(chunk_rdy_o), .chunk_end_o(chunk_end_o), .chunk_park_o(chunk_park_o),
        .be_req_o(be_req_o), .be_op_o(be_op_o), .be_addr_o(be_addr_o), .be_off_o(be_off_o),
        .be_len_o(be_len_o), .be_done_i(be_done_i), .be_err_i(be_err_i),
        .status_o(status_o), .irq_o(irq_o), .err_o(err_o), .active_o(active_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic start_xfer(input logic [1:0] cmd, input logic [7:0] ns,
                              input logic [27:0] lba, input bit opt, input logic [23:0] pkt);
        @(negedge clk);
        start_i = 1'b1; cmd_i = cmd; nsect_i = ns; lba_i = lba;
        optical_i = opt; pkt_size_i = pkt;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic send_chunk(input logic [31:0] addr, input logic [15:0] len);
        chunk_vld_i = 1'b1; chunk_addr_i = addr; chunk_len_i = len;
        @(negedge clk);
        chunk_vld_i = 1'b0;
    endtask

    // kind: 0 timeout, 1 request, 2 chunk end, 3 park
    task automatic wait_evt(output int kind);
        kind = 0;
        for (int i = 0; i < 20; i++) begin
            if (be_req_o)     begin kind = 1; return; end
            if (chunk_end_o)  begin kind = 2; return; end
            if (chunk_park_o) begin kind = 3; return; end
            @(negedge clk);
        end
    endtask

    task automatic finish_req(input bit err);
        be_done_i = 1'b1; be_err_i = err;
        @(negedge clk);
        be_done_i = 1'b0; be_err_i = 1'b0;
    endtask

    task automatic expect_req(input string req, input int op, input longint off,
                              input int len, input logic [31:0] addr);
        int k;
        wait_evt(k);
        chk(k == 1, req, "request issued", k, 1);
        if (k == 1) begin
            chk(be_op_o == op[1:0], req, "op", be_op_o, op);
            chk(be_off_o == off[39:0], req, "offset", be_off_o, off);
            chk(be_len_o == len[15:0], req, "length", be_len_o, len);
            chk(be_addr_o == addr, req, "address", be_addr_o, addr);
            chk(!chunk_rdy_o, "R6", "rdy low while pending", chunk_rdy_o, 0);
            repeat (3) @(negedge clk);
            chk(be_req_o && be_off_o == off[39:0], "R6", "request held", be_req_o, 1);
        end
    endtask

    task automatic expect_end(input string req, input bit irq, input bit act, input logic [7:0] st);
        int k;
        wait_evt(k);
        chk(k == 2, req, "chunk end", k, 2);
        chk(irq_o == irq, req, "irq", irq_o, irq);
        chk(active_o == act, req, "active", active_o, act);
        chk(status_o == st, req, "status", status_o, st);
    endtask

    task automatic t_reset;
        chk(status_o == 8'h00, "R1", "status", status_o, 0);
        chk(!irq_o && !err_o && !active_o, "R1", "irq/err/active", {irq_o, err_o, active_o}, 0);
        chk(chunk_rdy_o, "R1", "ready", chunk_rdy_o, 1);
    endtask

    task automatic t_disk_read;
        start_xfer(2'd0, 8'd2, 28'd5, 1'b0, 24'd0);
        chk(status_o == 8'h80 && active_o && !irq_o, "R2", "after start", status_o, 8'h80);
        send_chunk(32'h1000, 16'd512);
        expect_req("R3", 0, 64'd2560, 512, 32'h1000);
        finish_req(1'b0);
        expect_end("R4", 1'b0, 1'b1, 8'h80);
        @(negedge clk);
        send_chunk(32'h1200, 16'd512);
        expect_req("R4", 0, 64'd3072, 512, 32'h1200);
        finish_req(1'b0);
        expect_end("R8", 1'b1, 1'b0, 8'h50);
    endtask

    task automatic t_park;
        int k;
        @(negedge clk);
        send_chunk(32'h3000, 16'd512);
        wait_evt(k);
        chk(k == 3, "R7", "park pulse", k, 3);
        @(negedge clk);
        chk(!be_req_o && !active_o, "R7", "no request", be_req_o, 0);
    endtask

    task automatic t_optical_write;
        start_xfer(2'd1, 8'd0, 28'd3, 1'b1, 24'd4096);
        chk(!irq_o && active_o, "R2", "irq cleared", irq_o, 0);
        send_chunk(32'h4000, 16'd0);
        expect_end("R9", 1'b0, 1'b1, 8'h80);
        @(negedge clk);
        send_chunk(32'h4000, 16'd2048);
        expect_req("R5", 1, 64'd6144, 2048, 32'h4000);
        finish_req(1'b0);
        expect_end("R4", 1'b0, 1'b1, 8'h80);
        @(negedge clk);
        send_chunk(32'h4800, 16'd2048);
        expect_req("R3", 1, 64'd8192, 2048, 32'h4800);
        finish_req(1'b0);
        expect_end("R8", 1'b1, 1'b0, 8'h50);
    endtask

    task automatic t_trim_overshoot;
        start_xfer(2'd2, 8'd1, 28'd10, 1'b0, 24'd0);
        send_chunk(32'h5000, 16'd1024);
        expect_req("R5", 2, 64'd5120, 1024, 32'h5000);
        finish_req(1'b0);
        expect_end("R8", 1'b1, 1'b0, 8'h50);
    endtask

    task automatic t_zero_size;
        int k;
        start_xfer(2'd0, 8'd0, 28'd7, 1'b0, 24'd0);
        send_chunk(32'h6000, 16'd512);
        wait_evt(k);
        chk(k == 2, "R8", "immediate end without request", k, 2);
        chk(irq_o && status_o == 8'h50 && !active_o, "R8", "status", status_o, 8'h50);
    endtask

    task automatic t_copy(input logic [23:0] pkt, input int exp_len);
        start_xfer(2'd0, 8'd0, 28'hFFF_FFFF, 1'b1, pkt);
        send_chunk(32'h7000, 16'd300);
        expect_req("R10", 3, 64'd0, exp_len, 32'h7000);
        finish_req(1'b0);
        expect_end("R10", 1'b1, 1'b0, 8'h50);
    endtask

    task automatic t_be_error;
        start_xfer(2'd0, 8'd4, 28'd1, 1'b0, 24'd0);
        send_chunk(32'h8000, 16'd512);
        expect_req("R11", 0, 64'd512, 512, 32'h8000);
        finish_req(1'b1);
        expect_end("R11", 1'b1, 1'b0, 8'h41);
        chk(err_o, "R11", "err flag", err_o, 1);
    endtask

    task automatic t_bad_cmd;
        int k;
        start_xfer(2'd3, 8'd1, 28'd2, 1'b0, 24'd0);
        chk(!err_o, "R2", "err cleared by start", err_o, 0);
        send_chunk(32'h9000, 16'd512);
        wait_evt(k);
        chk(k == 2, "R12", "no request, chunk end", k, 2);
        chk(err_o && irq_o && status_o == 8'h41 && !active_o, "R12", "abort status",
            status_o, 8'h41);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_disk_read();
        t_park();
        t_optical_write();
        t_trim_overshoot();
        t_zero_size();
        t_copy(24'd100, 100);
        t_copy(24'd400, 300);
        t_be_error();
        t_bad_cmd();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule